// File: doc/BRIEF.md
# Input Gain Auto-Limiter Controller

This block holds the 7-bit gain code that is shared by the left and right input amplifiers. An external level detector raises a pulse when either channel goes above its threshold. The controller responds by lowering the common gain code by a programmable number of codes. Each code is worth 0.5 dB. The code never goes below 00h, which is the mute code.

A gain change does not take effect at once. It is applied on an update event, and a mode bit selects the kind of event:
- A fixed period, counted in sample-rate ticks.
- The next zero-crossing pulse. If no crossing arrives, a timeout of the same length forces the update.

The host writes a gain code in one of two ways:
- With the limiter enabled (semi-automatic operation), the code becomes a target. The controller moves toward it by one code per update event.
- With the limiter disabled (manual operation), the code is loaded directly.

A single `done` output tells the host when no gain change is pending. After disabling the limiter, the host waits for `done` before it reconfigures the block.

A power-down input returns the gain to 30h and clears the step field. After power-down is released, a fixed initialization period runs, and `done` stays low until it ends.

Top module: `gain_limiter_top`

## Requirements
- R1: With step field value s (3 bits, 000 to 111), one limiter step lowers the gain by s+1 codes. For example, gain 68h with s = 111 becomes 60h.
- R2: An `over_lvl` pulse schedules exactly one limiter step, but only while the limiter is enabled and the block is active. Further pulses before that step is applied add nothing. A pulse while the limiter is disabled leaves the gain and `done` unchanged.
- R3: If the result of a limiter step would go below 00h, it saturates at 00h.
- R4: With the timing bit set to 1, an update is applied after P = TICK_BASE << period sample ticks of a pending change. Zero-crossing pulses are ignored in this mode. The timer restarts after each applied update.
- R5: With the timing bit set to 0, an update is applied on the first `zero_cross` pulse. If no pulse arrives, it is applied after P sample ticks.
- R6: With the limiter enabled, a host gain write sets a target. Each update event moves the gain one code toward the target. A limiter step takes priority over a move and replaces the target with its result.
- R7: `done` is 1 exactly when the block is active, no limiter step is pending, and the gain equals its target.
- R8: After power-down is released, `done` stays 0 for INIT_TICKS sample ticks. During that period, `over_lvl` pulses and gain writes are ignored.
- R9: While `pwr_down` is 1, the gain is 30h and the step field is held at 000. A step-field write during power-down has no effect.
- R10: With the limiter disabled, a gain write loads the code directly. If the limiter is disabled while a change is in progress, at most one more update is applied, and then `done` returns to 1.
- R11: The gain changes only on an update event, a manual write, power-down or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Power-down; holds gain at 30h and the step field at 000 |
| sample_tick | input | 1 | One-cycle pulse at the sample rate |
| over_lvl | input | 1 | Over-threshold pulse from either channel |
| zero_cross | input | 1 | Zero-crossing pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_limit_en | input | 1 | Limiter enable |
| cfg_timed | input | 1 | 1 = fixed-period updates, 0 = zero-crossing updates |
| cfg_period | input | 2 | Period select: P = TICK_BASE << value |
| cfg_step | input | 3 | Attenuation step field (value + 1 codes) |
| gain_we | input | 1 | Gain write strobe |
| gain_wdata | input | 7 | Gain code to write |
| gain_code | output | 7 | Current shared gain code |
| done | output | 1 | No gain change in progress |

## Verification
The hardest case to reach is the limiter being disabled while a multi-code walk is still under way. To get there, the stimulus first sets a distant target under the longest period, so the walk lasts for many update events. The enable is then cleared partway through. The reference model then checks, on every clock, that the gain moves by at most one more code and that `done` returns.

A second hard case is the zero-crossing timeout. The stimulus gets there by stopping crossing pulses in the middle of a walk.

// File: rtl/gl_pkg.sv
package gl_pkg;

    localparam int GAIN_W = 7;

    typedef logic [GAIN_W-1:0] gain_t;

    localparam gain_t GAIN_RST  = 7'h30;
    localparam gain_t GAIN_MUTE = 7'h00;

    typedef struct packed {
        logic       limit_en;
        logic       timed;
        logic [1:0] period;
        logic [2:0] step;
    } cfg_t;

    // Lower g by (s+1) codes, stopping at the mute code.
    function automatic gain_t sat_sub(gain_t g, logic [2:0] s);
        logic [GAIN_W:0] amt;
        amt = {{(GAIN_W-2){1'b0}}, s} + 1'b1;
        if ({1'b0, g} <= amt)
            return GAIN_MUTE;
        else
            return g - amt[GAIN_W-1:0];
    endfunction

endpackage

// File: rtl/gl_event_timer.sv
module gl_event_timer #(
    parameter int TICK_BASE = 2,
    parameter int CNT_W     = 4
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       run,
    input  logic       sample_tick,
    input  logic       timed,
    input  logic [1:0] period,
    input  logic       zero_cross,
    output logic       update
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   lim;
    logic             expire;

    assign lim    = ((CNT_W+1)'(TICK_BASE) << period) - 1'b1;
    assign expire = sample_tick && ({1'b0, cnt_q} >= lim);
    assign update = run && (expire || (!timed && zero_cross));

    always_ff @(posedge clk) begin
        if (clr || !run)
            cnt_q <= '0;
        else if (update)
            cnt_q <= '0;
        else if (sample_tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // R4: in timed mode, a crossing pulse alone never fires an update.
    a_r4_timed_ignores_zc: assert property (@(posedge clk) disable iff (clr)
        (timed && !sample_tick) |-> !update);

endmodule

// File: rtl/gl_gain_core.sv
module gl_gain_core
    import gl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       active,
    input  logic       limit_en,
    input  logic [2:0] step,
    input  logic       over_lvl,
    input  logic       update,
    input  logic       gain_we,
    input  gain_t      gain_wdata,
    output gain_t      gain,
    output logic       busy
);

    gain_t gain_q, tgt_q, gain_n, tgt_n, lim_val, walk_val;
    logic  pend_q, pend_n;
    logic  man_wr;

    assign lim_val  = sat_sub(gain_q, step);
    assign walk_val = (tgt_q > gain_q) ? gain_q + 1'b1 : gain_q - 1'b1;
    assign man_wr   = active && gain_we && !limit_en;

    always_comb begin
        gain_n = gain_q;
        tgt_n  = tgt_q;
        pend_n = pend_q;
        if (update) begin
            if (pend_q) begin
                gain_n = lim_val;
                tgt_n  = lim_val;
                pend_n = 1'b0;
            end else if (gain_q != tgt_q) begin
                gain_n = walk_val;
            end
            if (!limit_en)
                tgt_n = gain_n;
        end
        if (active && limit_en && over_lvl)
            pend_n = 1'b1;
        if (active && gain_we) begin
            if (limit_en) begin
                tgt_n = gain_wdata;
            end else begin
                gain_n = gain_wdata;
                tgt_n  = gain_wdata;
                pend_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            gain_q <= GAIN_RST;
            tgt_q  <= GAIN_RST;
            pend_q <= 1'b0;
        end else begin
            gain_q <= gain_n;
            tgt_q  <= tgt_n;
            pend_q <= pend_n;
        end
    end

    assign gain = gain_q;
    assign busy = pend_q || (gain_q != tgt_q);

    // R3: a limiter step never raises the gain.
    a_r3_limit_no_rise: assert property (@(posedge clk) disable iff (rst)
        (!clr && update && pend_q && !man_wr) |=> (gain_q <= $past(gain_q)));

    // R1: a limiter step removes at most eight codes.
    a_r1_step_depth: assert property (@(posedge clk) disable iff (rst)
        (!clr && update && pend_q && !man_wr)
        |=> ({1'b0, gain_q} + 8'd8 >= {1'b0, $past(gain_q)}));

    // R6: a walk update moves exactly one code.
    a_r6_walk_unit: assert property (@(posedge clk) disable iff (rst)
        (!clr && update && !pend_q && (gain_q != tgt_q) && !man_wr)
        |=> ((gain_q == $past(gain_q) + 7'd1) || (gain_q == $past(gain_q) - 7'd1)));

    // R11: no update, no manual write, no clear -> the gain holds.
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !update && !man_wr) |=> $stable(gain_q));

endmodule

// File: rtl/gain_limiter_top.sv
module gain_limiter_top
    import gl_pkg::*;
#(
    parameter int TICK_BASE  = 2,
    parameter int INIT_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_down,
    input  logic       sample_tick,
    input  logic       over_lvl,
    input  logic       zero_cross,
    input  logic       cfg_we,
    input  logic       cfg_limit_en,
    input  logic       cfg_timed,
    input  logic [1:0] cfg_period,
    input  logic [2:0] cfg_step,
    input  logic       gain_we,
    input  logic [6:0] gain_wdata,
    output logic [6:0] gain_code,
    output logic       done
);

    localparam int CNT_W  = $clog2(TICK_BASE * 8);
    localparam int INIT_W = $clog2(INIT_TICKS + 1);

    cfg_t              cfg_q;
    logic [INIT_W-1:0] init_q;
    logic              clr, active, busy, update;

    assign clr    = rst || pwr_down;
    assign active = !pwr_down && (init_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (cfg_we)
                cfg_q <= '{limit_en: cfg_limit_en, timed: cfg_timed,
                           period: cfg_period, step: cfg_step};
            if (pwr_down)
                cfg_q.step <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (clr)
            init_q <= INIT_W'(INIT_TICKS);
        else if (sample_tick && init_q != '0)
            init_q <= init_q - 1'b1;
    end

    gl_event_timer #(
        .TICK_BASE (TICK_BASE),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk         (clk),
        .clr         (clr),
        .run         (busy),
        .sample_tick (sample_tick),
        .timed       (cfg_q.timed),
        .period      (cfg_q.period),
        .zero_cross  (zero_cross),
        .update      (update)
    );

    gl_gain_core u_core (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .active     (active),
        .limit_en   (cfg_q.limit_en),
        .step       (cfg_q.step),
        .over_lvl   (over_lvl),
        .update     (update),
        .gain_we    (gain_we),
        .gain_wdata (gain_wdata),
        .gain       (gain_code),
        .busy       (busy)
    );

    assign done = active && !busy;

    // R8: the cycle after power-down is released, the block is still initializing.
    a_r8_init_not_done: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_down) |=> !done);

    // R9: power-down forces the reset gain code.
    a_r9_pd_gain: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (gain_code == GAIN_RST));

    // R9: power-down clears the step field.
    a_r9_pd_step: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (cfg_q.step == 3'd0));

endmodule

// File: tb/gain_limiter_top_bench.sv
module gain_limiter_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TB_BASE    = 2;
    localparam int TB_INIT    = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_down = 1'b0;
    logic       sample_tick = 1'b0;
    logic       over_lvl = 1'b0;
    logic       zero_cross = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_limit_en = 1'b0;
    logic       cfg_timed = 1'b0;
    logic [1:0] cfg_period = 2'd0;
    logic [2:0] cfg_step = 3'd0;
    logic       gain_we = 1'b0;
    logic [6:0] gain_wdata = 7'd0;
    logic [6:0] gain_code;
    logic       done;

    int    n_vec = 0;
    int    n_bad = 0;
    string phase_req = "R9";
    bit    finished = 0;

    // reference model state
    int m_gain, m_tgt, m_cnt, m_init;
    bit m_pend, m_en, m_timed;
    int m_period, m_step;

    gain_limiter_top #(.TICK_BASE(TB_BASE), .INIT_TICKS(TB_INIT)) u_gain_limiter_top (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .sample_tick(sample_tick),
        .over_lvl(over_lvl), .zero_cross(zero_cross), .cfg_we(cfg_we),
        .cfg_limit_en(cfg_limit_en), .cfg_timed(cfg_timed), .cfg_period(cfg_period),
        .cfg_step(cfg_step), .gain_we(gain_we), .gain_wdata(gain_wdata),
        .gain_code(gain_code), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int tc;
        tc = 0;
        forever begin
            @(posedge clk); #1;
            tc++;
            sample_tick = (tc % 4 == 0);
        end
    end

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        bit act, busy, upd;
        int lim, ng, nt, amt;
        bit np;
        if (rst) begin
            m_gain = 48; m_tgt = 48; m_pend = 0; m_cnt = 0; m_init = TB_INIT;
            m_en = 0; m_timed = 0; m_period = 0; m_step = 0;
        end else begin
            act  = !pwr_down && m_init == 0;
            busy = m_pend || (m_gain != m_tgt);
            lim  = (TB_BASE << m_period) - 1;
            upd  = busy && ((sample_tick && m_cnt >= lim) || (!m_timed && zero_cross));
            ng = m_gain; nt = m_tgt; np = m_pend;
            if (upd) begin
                if (m_pend) begin
                    amt = m_step + 1;
                    ng = (m_gain <= amt) ? 0 : m_gain - amt;
                    nt = ng; np = 0;
                end else if (m_gain != m_tgt) begin
                    ng = (m_tgt > m_gain) ? m_gain + 1 : m_gain - 1;
                end
                if (!m_en) nt = ng;
            end
            if (act && m_en && over_lvl) np = 1;
            if (act && gain_we) begin
                if (m_en) nt = gain_wdata;
                else begin ng = gain_wdata; nt = gain_wdata; np = 0; end
            end
            if (pwr_down || !busy || upd) m_cnt = 0;
            else if (sample_tick) m_cnt = m_cnt + 1;
            if (pwr_down) begin
                m_gain = 48; m_tgt = 48; m_pend = 0; m_init = TB_INIT;
            end else begin
                m_gain = ng; m_tgt = nt; m_pend = np;
                if (sample_tick && m_init != 0) m_init = m_init - 1;
            end
            if (cfg_we) begin
                m_en = cfg_limit_en; m_timed = cfg_timed;
                m_period = cfg_period; m_step = cfg_step;
            end
            if (pwr_down) m_step = 0;
        end
    end

    task automatic chk(string req, int got, int exp, string what);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(phase_req, gain_code, m_gain, "gain_code vs model");
            chk(phase_req, done,
                (!pwr_down && m_init == 0 && !m_pend && m_gain == m_tgt) ? 1 : 0,
                "done vs model");
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic set_cfg(bit en, bit timed, int per, int st);
        cfg_limit_en = en; cfg_timed = timed; cfg_period = 2'(per); cfg_step = 3'(st);
        cfg_we = 1; cyc(); cfg_we = 0;
    endtask

    task automatic wr_gain(int g);
        gain_wdata = 7'(g); gain_we = 1; cyc(); gain_we = 0;
    endtask

    task automatic pulse_over();
        over_lvl = 1; cyc(); over_lvl = 0;
    endtask

    task automatic wait_done();
        cyc(2);
        for (int i = 0; i < 3000 && !done; i++) cyc();
    endtask

    initial begin
        int exp_g;
        cyc(3);
        phase_req = "R9";
        chk("R9", gain_code, 'h30, "gain after reset");
        rst = 0;
        cyc(1);
        phase_req = "R8";
        chk("R8", done, 0, "done during init");
        wait_done();
        chk("R7", done, 1, "done once idle");

        // semi-auto walk from 30h up to 68h, timed mode, shortest period
        phase_req = "R6";
        set_cfg(1, 1, 0, 7);
        wr_gain('h68);
        cyc(1);
        chk("R6", done, 0, "done low during walk");
        wait_done();
        chk("R6", gain_code, 'h68, "walk target reached");

        // one limiter step of eight codes
        phase_req = "R1";
        pulse_over();
        wait_done();
        chk("R1", gain_code, 'h60, "68h minus 8 codes");

        // every step size
        exp_g = 'h60;
        for (int s = 0; s < 8; s++) begin
            set_cfg(1, 1, s % 4, s);
            pulse_over();
            wait_done();
            exp_g = exp_g - (s + 1);
            chk("R1", gain_code, exp_g, "step size sweep");
        end

        // R2: several pulses before an update give a single step
        phase_req = "R2";
        set_cfg(1, 1, 3, 1);
        exp_g = gain_code;
        pulse_over(); pulse_over(); pulse_over();
        wait_done();
        chk("R2", gain_code, exp_g - 2, "repeated pulses give one step");

        // manual load, then clip at mute
        phase_req = "R10";
        set_cfg(0, 1, 0, 7);
        wr_gain(5);
        cyc(1);
        chk("R10", gain_code, 5, "manual write loads directly");
        phase_req = "R3";
        set_cfg(1, 1, 0, 7);
        pulse_over();
        wait_done();
        chk("R3", gain_code, 0, "saturate at mute");

        // zero-crossing mode walk with crossings, then timeout
        phase_req = "R5";
        set_cfg(1, 0, 3, 0);
        wr_gain(12);
        for (int k = 0; k < 6; k++) begin
            cyc(3); zero_cross = 1; cyc(); zero_cross = 0;
        end
        chk("R5", gain_code, 6, "one code per crossing");
        wait_done();
        chk("R5", gain_code, 12, "timeout completes walk");

        // timed mode ignores crossings
        phase_req = "R4";
        set_cfg(1, 1, 3, 0);
        wr_gain(2);
        for (int k = 0; k < 10; k++) begin
            cyc(2); zero_cross = 1; cyc(); zero_cross = 0;
        end
        chk("R4", gain_code, 12, "crossings ignored in timed mode");
        wait_done();
        chk("R4", gain_code, 2, "timed walk completes");

        // disable mid-walk
        phase_req = "R10";
        set_cfg(1, 1, 3, 0);
        wr_gain(60);
        cyc(150);
        exp_g = gain_code;
        set_cfg(0, 1, 3, 0);
        wait_done();
        chk("R10", (gain_code - exp_g <= 1) ? 1 : 0, 1, "at most one step after disable");

        // over_lvl while disabled
        phase_req = "R2";
        exp_g = gain_code;
        pulse_over();
        cyc(80);
        chk("R2", gain_code, exp_g, "pulse ignored when disabled");
        chk("R2", done, 1, "done held when disabled");

        // power-down: step write ignored, init ignores pulses
        phase_req = "R9";
        pwr_down = 1;
        cyc(2);
        set_cfg(1, 1, 0, 7);
        chk("R9", gain_code, 'h30, "gain in power-down");
        chk("R9", done, 0, "done in power-down");
        pwr_down = 0;
        phase_req = "R8";
        cyc(2);
        pulse_over();
        wr_gain(20);
        cyc(10);
        chk("R8", gain_code, 'h30, "init ignores pulse and write");
        wait_done();
        phase_req = "R9";
        pulse_over();
        wait_done();
        chk("R9", gain_code, 'h2F, "step field cleared by power-down");

        phase_req = "R11";
        cyc(40);
        chk("R11", gain_code, 'h2F, "gain holds when idle");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL %s watchdog: got timeout expected completion", phase_req);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule